// File: doc/BRIEF.md
# Level-Run Waveform List Builder

This block keeps two bounded lists of run durations. Each list describes a waveform with two levels. A list stores the level of its first run. Every later run has the opposite level of the run before it, so the level of any run follows from the stored start level and the run's position. A command port accepts three kinds of command. A raw add stores a duration as a new run. A pulse add takes a level and a duration and merges it into the last run when the two levels match. An append copies the other list onto the end of the target list, and it merges the two runs that meet at the seam when they have the same level.

Commands use a valid/ready handshake. An append that moves N runs takes N clock cycles, one run per cycle. During that time `busy_o` is high and `cmd_ready` is low. A command that would overflow a list changes nothing and raises a one-cycle flag. A register-file style read port returns the run count and the start level of a chosen list at once, and returns any stored duration one cycle after the address is applied.

Top module: `run_list_builder`

## Requirements
- R1: After reset both lists hold 0 runs and have start level 1. `busy_o`, `rej_o` and `ovf_o` are low and `cmd_ready` is high.
- R2: A raw add (`cmd_op` = 2'b00) stores `cmd_dur` as a new run at index = old count and increments the count. It applies no level check and leaves the start level unchanged.
- R3: A pulse add (`cmd_op` = 2'b01) to an empty list sets the start level to `cmd_level` and stores `cmd_dur` as the only run.
- R4: The level of the last run equals the start level when the count is odd, and its inverse when the count is even. A pulse whose level differs from that last level becomes a new run. A pulse with the same level adds its duration to the last run and leaves the count unchanged.
- R5: A raw or pulse add to a list that already holds DEPTH runs is ignored. `ovf_o` is high for the one cycle after the command is accepted.
- R6: An append (`cmd_op` = 2'b10, target `cmd_list`, source the other list) is rejected when target count + source count > DEPTH. This holds even when a seam merge would make the result fit. A rejected append changes neither list, pulses `rej_o` for one cycle, and does not raise `busy_o`.
- R7: An append to an empty target gives the target the source's start level and copies every source run.
- R8: When the target is not empty and its last level equals the source start level, an append adds the first source duration to the last target run and copies the remaining runs, so the count becomes d+s-1. Otherwise it copies all runs, so the count becomes d+s.
- R9: An accepted append of N>0 runs holds `busy_o` high, with `cmd_ready` low, for exactly N cycles. It changes the counts by at most one run per cycle and leaves the source list unchanged.
- R10: `cmd_op` = 2'b11 is accepted and has no effect: no list change, no flag, no busy.
- R11: `q_cnt` and `q_start` show the list selected by `q_list` combinationally. `q_data` shows the run at `q_addr` of that list one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high together with valid |
| cmd_op | input | 2 | 00 raw add, 01 pulse add, 10 append, 11 no operation |
| cmd_list | input | 1 | Target list (the append source is the other list) |
| cmd_level | input | 1 | Level of a pulse add |
| cmd_dur | input | DW | Duration for raw or pulse add |
| busy_o | output | 1 | Append copy in progress |
| rej_o | output | 1 | One-cycle pulse: append rejected |
| ovf_o | output | 1 | One-cycle pulse: add ignored, list full |
| q_list | input | 1 | List selected for query |
| q_addr | input | AW | Run index to read |
| q_cnt | output | CW | Run count of the selected list |
| q_start | output | 1 | Start level of the selected list |
| q_data | output | DW | Duration at q_addr, registered |

## Verification
The bench targets the seam of an append in both polarities. A design that ignored the merge would leave one run too many with split durations, and one that always merged would fold runs of opposite level together. It runs pulse sequences that alternate between merging and new runs, where getting the parity of the last level wrong changes the count. It also covers an append into an empty list, where a design that kept its own start level would invert the whole copied waveform. Finally it checks overflow at exactly full and the append whose merged result would fit but whose raw sum does not. A design that tested the merged count would accept that append, and one that let an add through at full would write past the end.

// File: rtl/rlb_pkg.sv
package rlb_pkg;

    typedef enum logic [1:0] {
        OP_RAW    = 2'b00,
        OP_PULSE  = 2'b01,
        OP_APPEND = 2'b10,
        OP_NOP    = 2'b11
    } op_e;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_RUN  = 1'b1
    } walk_st_e;

    // Per-list write request produced by the control logic
    typedef struct packed {
        logic push;       // store duration as a new run
        logic acc;        // add duration to the last run
        logic set_start;  // load a new start level
        logic start_val;
    } wr_req_t;

    // Level of the last run: odd count -> start level, even -> inverse
    function automatic logic tail_level(input logic start, input logic odd_cnt);
        return odd_cnt ? start : ~start;
    endfunction

endpackage

// File: rtl/rlb_store.sv
module rlb_store
    import rlb_pkg::*;
#(
    parameter  int DEPTH = 64,
    parameter  int DW    = 32,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       req,
    input  logic [DW-1:0] dur,
    output logic [CW-1:0] cnt_o,
    output logic          start_o,
    input  logic [AW-1:0] rd_a_addr,
    output logic [DW-1:0] rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output logic [DW-1:0] rd_b_data
);

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic          start_q;
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] last_idx;

    assign wr_idx   = AW'(cnt_q);
    assign last_idx = AW'(cnt_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            start_q <= 1'b1;
        end else begin
            if (req.set_start) begin
                start_q <= req.start_val;
            end
            if (req.push) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (req.push) begin
                mem[wr_idx] <= dur;
            end else if (req.acc) begin
                mem[last_idx] <= mem[last_idx] + dur;
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign start_o   = start_q;
    assign rd_a_data = mem[rd_a_addr];
    assign rd_b_data = mem[rd_b_addr];

endmodule

// File: rtl/rlb_walker.sv
module rlb_walker
    import rlb_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [CW-1:0] src_cnt_i,
    input  logic          merge_i,
    output logic          busy_o,
    output logic          step_o,
    output logic          acc_o,
    output logic [AW-1:0] idx_o
);

    walk_st_e      st_q;
    logic [AW-1:0] idx_q;
    logic [AW-1:0] lim_q;
    logic          mfirst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= WK_IDLE;
            idx_q    <= '0;
            lim_q    <= '0;
            mfirst_q <= 1'b0;
        end else begin
            unique case (st_q)
                WK_IDLE: begin
                    if (start_i) begin
                        st_q     <= WK_RUN;
                        idx_q    <= '0;
                        lim_q    <= AW'(src_cnt_i - 1'b1);
                        mfirst_q <= merge_i;
                    end
                end
                WK_RUN: begin
                    if (idx_q == lim_q) begin
                        st_q <= WK_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    assign busy_o = (st_q == WK_RUN);
    assign step_o = (st_q == WK_RUN);
    assign acc_o  = mfirst_q && (idx_q == '0);
    assign idx_o  = idx_q;

endmodule

// File: rtl/run_list_builder.sv
module run_list_builder
    import rlb_pkg::*;
#(
    parameter  int DEPTH = 64,
    parameter  int DW    = 32,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_list,
    input  logic          cmd_level,
    input  logic [DW-1:0] cmd_dur,
    output logic          busy_o,
    output logic          rej_o,
    output logic          ovf_o,
    input  logic          q_list,
    input  logic [AW-1:0] q_addr,
    output logic [CW-1:0] q_cnt,
    output logic          q_start,
    output logic [DW-1:0] q_data
);

    localparam int NL = 2;

    logic [CW-1:0] cnt_w   [NL];
    logic          start_w [NL];
    logic [DW-1:0] rda_w   [NL];
    logic [DW-1:0] rdb_w   [NL];
    wr_req_t       req_w   [NL];
    logic [DW-1:0] wdur_w  [NL];

    logic          w_busy, w_step, w_acc;
    logic [AW-1:0] w_idx;

    op_e           op;
    logic          accept;
    logic          dsel, ssel;
    logic [CW-1:0] d_cnt, s_cnt;
    logic          d_full, d_tail, over, merge, app_go;
    logic [CW:0]   sum;
    logic          dst_q;
    logic          rej_q, ovf_q;
    logic [DW-1:0] q_data_q;

    // ---------------- command decode ----------------
    assign op        = op_e'(cmd_op);
    assign cmd_ready = !w_busy;
    assign accept    = cmd_valid && cmd_ready;
    assign dsel      = cmd_list;
    assign ssel      = ~cmd_list;
    assign d_cnt     = cnt_w[dsel];
    assign s_cnt     = cnt_w[ssel];
    assign d_full    = (d_cnt == CW'(DEPTH));
    assign d_tail    = tail_level(start_w[dsel], d_cnt[0]);
    assign sum       = {1'b0, d_cnt} + {1'b0, s_cnt};
    assign over      = (sum > (CW+1)'(DEPTH));
    assign merge     = (d_cnt != '0) && (d_tail == start_w[ssel]);
    assign app_go    = accept && (op == OP_APPEND) && !over && (s_cnt != '0);

    // ---------------- per-list storage ----------------
    for (genvar g = 0; g < NL; g++) begin : g_list
        localparam logic ME = 1'(g);

        always_comb begin
            req_w[g]  = '0;
            wdur_w[g] = cmd_dur;
            if (w_step) begin
                if (dst_q == ME) begin
                    req_w[g].push = !w_acc;
                    req_w[g].acc  = w_acc;
                    wdur_w[g]     = rdb_w[~ME];
                end
            end else if (accept && (dsel == ME)) begin
                unique case (op)
                    OP_RAW: begin
                        req_w[g].push = !d_full;
                    end
                    OP_PULSE: begin
                        if (!d_full) begin
                            if (d_cnt == '0) begin
                                req_w[g].set_start = 1'b1;
                                req_w[g].start_val = cmd_level;
                                req_w[g].push      = 1'b1;
                            end else if (cmd_level != d_tail) begin
                                req_w[g].push = 1'b1;
                            end else begin
                                req_w[g].acc = 1'b1;
                            end
                        end
                    end
                    OP_APPEND: begin
                        if (!over && (d_cnt == '0)) begin
                            req_w[g].set_start = 1'b1;
                            req_w[g].start_val = start_w[ssel];
                        end
                    end
                    default: ;
                endcase
            end
        end

        rlb_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
            .clk       (clk),
            .rst       (rst),
            .req       (req_w[g]),
            .dur       (wdur_w[g]),
            .cnt_o     (cnt_w[g]),
            .start_o   (start_w[g]),
            .rd_a_addr (q_addr),
            .rd_a_data (rda_w[g]),
            .rd_b_addr (w_idx),
            .rd_b_data (rdb_w[g])
        );
    end

    // ---------------- append sequencer ----------------
    rlb_walker #(.DEPTH(DEPTH)) walker_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (app_go),
        .src_cnt_i (s_cnt),
        .merge_i   (merge),
        .busy_o    (w_busy),
        .step_o    (w_step),
        .acc_o     (w_acc),
        .idx_o     (w_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_q    <= 1'b0;
            rej_q    <= 1'b0;
            ovf_q    <= 1'b0;
            q_data_q <= '0;
        end else begin
            if (app_go) begin
                dst_q <= dsel;
            end
            rej_q    <= accept && (op == OP_APPEND) && over;
            ovf_q    <= accept && ((op == OP_RAW) || (op == OP_PULSE)) && d_full;
            q_data_q <= rda_w[q_list];
        end
    end

    assign busy_o  = w_busy;
    assign rej_o   = rej_q;
    assign ovf_o   = ovf_q;
    assign q_cnt   = cnt_w[q_list];
    assign q_start = start_w[q_list];
    assign q_data  = q_data_q;

endmodule

// File: rtl/rlb_chk.sv
module rlb_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [1:0]    cmd_op,
    input logic          busy_o,
    input logic          rej_o,
    input logic          ovf_o,
    input logic [CW-1:0] cnt0,
    input logic [CW-1:0] cnt1
);

    // R1
    cap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt0 <= CW'(DEPTH)) && (cnt1 <= CW'(DEPTH)));

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> $stable(cnt0) && $stable(cnt1));

    // R6
    rej_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rej_o |-> $stable(cnt0) && $stable(cnt1) && !busy_o);

    // R9
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        $past(busy_o) |->
            ((cnt0 == $past(cnt0)) || (cnt0 == CW'($past(cnt0) + 1'b1))) &&
            ((cnt1 == $past(cnt1)) || (cnt1 == CW'($past(cnt1) + 1'b1))));

    // R10
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && (cmd_op == 2'b11)) |=>
            !busy_o && !rej_o && !ovf_o && $stable(cnt0) && $stable(cnt1));

    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rej_o && ovf_o));

endmodule

bind run_list_builder rlb_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .busy_o    (busy_o),
    .rej_o     (rej_o),
    .ovf_o     (ovf_o),
    .cnt0      (cnt_w[0]),
    .cnt1      (cnt_w[1])
);

// File: tb/run_list_builder_tb_top.sv
`timescale 1ns/100ps
module run_list_builder_tb_top;

    localparam int DEPTH = 64;
    localparam int DW    = 32;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'b00;
    logic          cmd_list = 1'b0;
    logic          cmd_level = 1'b0;
    logic [DW-1:0] cmd_dur = '0;
    logic          busy_o, rej_o, ovf_o;
    logic          q_list = 1'b0;
    logic [AW-1:0] q_addr = '0;
    logic [CW-1:0] q_cnt;
    logic          q_start;
    logic [DW-1:0] q_data;

    always #2.5 clk = ~clk;

    run_list_builder #(.DEPTH(DEPTH), .DW(DW)) dut_i (.*);

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // reference model
    logic [DW-1:0] mdur [2][DEPTH];
    int            mcnt [2];
    bit            mst  [2];

    // scoreboard
    logic [DW-1:0] exp_q [$];
    bit            pend   = 1'b0;
    bit            pend_d = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) pend_d <= pend;

    always @(negedge clk) begin
        if (pend_d) begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk(q_data == e, "R11", "q_data", q_data, e);
        end
    end

    function automatic bit mtail(input int l);
        return (mcnt[l] % 2 == 1) ? mst[l] : !mst[l];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int l = 0; l < 2; l++) begin
            mcnt[l] = 0;
            mst[l]  = 1'b1;
        end
    endtask

    // driver: updates the model from the requirements, drives, checks flags
    task automatic send(input logic [1:0] op, input int l, input bit lvl,
                        input logic [DW-1:0] dur, input string req);
        bit er = 1'b0, eo = 1'b0;
        int nb = 0;
        int s  = 1 - l;
        int cnt_busy = 0;
        case (op)
            2'b00: if (mcnt[l] == DEPTH) eo = 1'b1;
                   else begin mdur[l][mcnt[l]] = dur; mcnt[l]++; end
            2'b01: if (mcnt[l] == DEPTH) eo = 1'b1;
                   else if (mcnt[l] == 0) begin
                       mst[l] = lvl; mdur[l][0] = dur; mcnt[l] = 1;
                   end else if (lvl != mtail(l)) begin
                       mdur[l][mcnt[l]] = dur; mcnt[l]++;
                   end else begin
                       mdur[l][mcnt[l]-1] += dur;
                   end
            2'b10: if (mcnt[l] + mcnt[s] > DEPTH) er = 1'b1;
                   else begin
                       int first = 0;
                       nb = mcnt[s];
                       if (mcnt[l] == 0) mst[l] = mst[s];
                       else if (nb > 0 && mtail(l) == mst[s]) begin
                           mdur[l][mcnt[l]-1] += mdur[s][0];
                           first = 1;
                       end
                       for (int i = first; i < nb; i++) begin
                           mdur[l][mcnt[l]] = mdur[s][i]; mcnt[l]++;
                       end
                   end
            default: ;
        endcase
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_list = l[0]; cmd_level = lvl; cmd_dur = dur;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(rej_o == er, req, "rej_o", rej_o, er);
        chk(ovf_o == eo, req, "ovf_o", ovf_o, eo);
        while (busy_o) begin
            chk(!cmd_ready, "R9", "cmd_ready while busy", cmd_ready, 0);
            cnt_busy++;
            @(negedge clk);
        end
        if (op == 2'b10) chk(cnt_busy == nb, "R9", "busy cycles", cnt_busy, nb);
    endtask

    task automatic verify(input int l, input string req);
        @(negedge clk);
        q_list = l[0];
        #0.5;
        chk(q_cnt == CW'(mcnt[l]), req, "q_cnt", q_cnt, mcnt[l]);
        chk(q_start == mst[l], req, "q_start", q_start, mst[l]);
        for (int i = 0; i < mcnt[l]; i++) begin
            @(negedge clk);
            q_addr = AW'(i);
            exp_q.push_back(mdur[l][i]);
            pend = 1'b1;
        end
        @(negedge clk);
        pend = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        #0.5;
        chk(!busy_o && !rej_o && !ovf_o, "R1", "flags after reset", {busy_o, rej_o, ovf_o}, 0);
        chk(cmd_ready, "R1", "cmd_ready", cmd_ready, 1);
        verify(0, "R1");
        verify(1, "R1");

        // R2 raw adds keep start level, no level check
        send(2'b00, 0, 1'b0, 32'd5, "R2");
        send(2'b00, 0, 1'b1, 32'd7, "R2");
        verify(0, "R2");

        // R3 first pulse sets start level; R4 merge/new-run by parity
        send(2'b01, 1, 1'b0, 32'd3, "R3");
        verify(1, "R3");
        send(2'b01, 1, 1'b0, 32'd4, "R4");
        send(2'b01, 1, 1'b1, 32'd2, "R4");
        send(2'b01, 1, 1'b1, 32'd1, "R4");
        verify(1, "R4");

        // R8 seam merge: list0 ends at level 0, list1 starts at 0
        send(2'b10, 0, 1'b0, 32'd0, "R8");
        verify(0, "R8");
        verify(1, "R9");
        // R8 no merge: list0 now odd count ends at 1, list1 starts at 0
        send(2'b10, 0, 1'b0, 32'd0, "R8");
        verify(0, "R8");

        // R10 no-op
        send(2'b11, 0, 1'b1, 32'd99, "R10");
        verify(0, "R10");

        // R7 append into empty list takes source start level
        do_reset();
        send(2'b01, 1, 1'b0, 32'd4, "R7");
        send(2'b01, 1, 1'b1, 32'd6, "R7");
        send(2'b01, 1, 1'b0, 32'd8, "R7");
        send(2'b10, 0, 1'b0, 32'd0, "R7");
        verify(0, "R7");
        verify(1, "R7");

        // R6 raw sum over capacity rejected even though a merge would fit
        do_reset();
        for (int i = 0; i < DEPTH - 1; i++) send(2'b00, 0, 1'b0, DW'(i + 1), "R2");
        send(2'b01, 1, 1'b1, 32'd11, "R6");
        send(2'b01, 1, 1'b0, 32'd12, "R6");
        send(2'b10, 0, 1'b0, 32'd0, "R6");
        verify(0, "R6");

        // R5 add on full list ignored
        send(2'b00, 0, 1'b0, 32'd77, "R2");
        send(2'b00, 0, 1'b0, 32'd88, "R5");
        send(2'b01, 0, 1'b1, 32'd88, "R5");
        send(2'b01, 0, 1'b0, 32'd88, "R5");
        verify(0, "R5");

        // R8 exact fit without merge
        do_reset();
        for (int i = 0; i < DEPTH - 2; i++) send(2'b00, 0, 1'b0, DW'(100 + i), "R2");
        send(2'b01, 1, 1'b1, 32'd21, "R8");
        send(2'b01, 1, 1'b0, 32'd22, "R8");
        send(2'b10, 0, 1'b0, 32'd0, "R8");
        verify(0, "R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule